// File: doc/BRIEF.md
# Auto-Incrementing Serial Control Register Bank

This block is a two-wire serial bus slave that holds a bank of 8-bit control registers. The registers come out of reset with a fixed default value and are presented in parallel on a flat output vector, so that the rest of the chip can use them directly. The block has no register pointer that a controller can set. Every access starts at register 0 and moves up by one register per byte until the controller ends the transfer.

A write transfer has four parts in a fixed order: the device address byte with direction 0, a command byte, a byte-count byte, and then the data bytes. The command and byte-count bytes are acknowledged but discarded. The data bytes fill register 0, register 1 and onwards. A read transfer has no command phase. Register 0 is shifted out straight after the address acknowledge, and each later register follows each time the controller acknowledges.

The clock and data lines are resampled through two-flop synchronizers and all bus events are detected on the system clock. The data line is driven open-drain: the block only ever pulls it low, through a single drive-enable output.

Top module: `i2c_seq_regfile`

## Requirements
- R1: After reset every register holds RESET_BYTE (default 0x3C) and the data drive-enable is low. Register i appears on regs_o[8*i+7 : 8*i].
- R2: An address byte whose upper seven bits equal DEV_ADDR (default 0x69, which makes 0xD2 for a write and 0xD3 for a read) is acknowledged by pulling the data line low during the ninth clock.
- R3: An address byte with any other value is not acknowledged. All following bytes up to the next start condition get no acknowledge and change no register.
- R4: In a write, the two bytes after the address (command, then byte count) are acknowledged whatever their value, and neither one is stored.
- R5: Write data bytes go to register 0, then 1, then 2 and so on, each one acknowledged. Registers the transfer does not reach keep their value, and registers change only on such a data byte.
- R6: In a read, register 0 is sent right after the address acknowledge, MSB first, and the next register follows after each controller acknowledge.
- R7: When the controller does not acknowledge a read byte, the block releases the data line and drives nothing more until the next start. A stop condition always leaves the data line released.
- R8: A write data byte past the last register is not acknowledged and is not stored. A read that goes past the last register leaves the line released, so the controller reads 0xFF.
- R9: A start condition in the middle of a transfer restarts the sequence at the address byte. The drive-enable changes only after a falling clock, a start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When high, pull the data line low |
| regs_o | output | NREG*8 | All registers, register i in bits 8*i+7 : 8*i |

## Verification
Writes of different lengths are used, with both a zero and a non-zero command byte. Comparing register contents after each write shows whether the command and count bytes are really skipped and whether the untouched higher registers keep their values. A foreign address followed by data shows whether the block ignores the bus until the next start. Reads with acknowledge and without acknowledge, and transfers that run past the last register, separate correct sequencing from wrap-around or from driving the line after the controller has given it up. Two cases use a repeated start: one inside a write and one that turns a write into a read. These show that the byte phase restarts on a start condition and does not carry over the previous transfer's position.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_CMD,
    BY_CNT,
    BY_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
      prev <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], line_i};
      prev <= pipe[STAGES-1];
    end
  end

  assign level_o = pipe[STAGES-1];
  assign rise_o  = pipe[STAGES-1] & ~prev;
  assign fall_o  = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int         NREG       = 8,
  parameter logic [7:0] RESET_BYTE = 8'h3C,
  localparam int        IW         = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [7:0]      wdata,
  input  logic [IW-1:0]   ridx,
  output logic [7:0]      rdata,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= RESET_BYTE;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[8*g +: 8] = mem[g];
  end
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int         NREG     = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IW       = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int        AW       = $clog2(NREG + 1) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_evt,
  input  logic          stop_evt,
  output logic          sda_oe,
  output logic          we,
  output logic [IW-1:0] widx,
  output logic [7:0]    wdata,
  output logic [IW-1:0] ridx,
  input  logic [7:0]    rdata,
  output bus_st_e       state_o
);
  localparam logic [AW-1:0] LAST = AW'(NREG);

  bus_st_e    state;
  byte_kind_e kind;
  logic          rw, full, mack;
  logic [7:0]    shreg, txsh;
  logic [2:0]    bitcnt;
  logic [AW-1:0] ptr, ptr_nx;

  assign ptr_nx  = ptr + 1'b1;
  assign ridx    = (state == ST_MACK) ? ptr_nx[IW-1:0] : ptr[IW-1:0];
  assign state_o = state;

  function automatic byte_kind_e next_kind(input byte_kind_e k);
    case (k)
      BY_ADDR: return BY_CMD;
      BY_CMD:  return BY_CNT;
      default: return BY_DATA;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      kind   <= BY_ADDR;
      sda_oe <= 1'b0;
      we     <= 1'b0;
      widx   <= '0;
      wdata  <= '0;
      rw     <= 1'b0;
      full   <= 1'b0;
      mack   <= 1'b1;
      shreg  <= '0;
      txsh   <= '0;
      bitcnt <= '0;
      ptr    <= '0;
    end else begin
      we <= 1'b0;
      if (start_evt) begin
        state  <= ST_RX;
        kind   <= BY_ADDR;
        bitcnt <= '0;
        full   <= 1'b0;
        ptr    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              case (kind)
                BY_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    state  <= ST_ACK;
                    sda_oe <= 1'b1;
                    rw     <= shreg[0];
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                BY_DATA: begin
                  if (ptr < LAST) begin
                    state  <= ST_ACK;
                    sda_oe <= 1'b1;
                    we     <= 1'b1;
                    widx   <= ptr[IW-1:0];
                    wdata  <= shreg;
                    ptr    <= ptr_nx;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                default: begin
                  state  <= ST_ACK;
                  sda_oe <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (kind == BY_ADDR && rw) begin
                state  <= ST_TX;
                txsh   <= rdata;
                sda_oe <= ~rdata[7];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
                kind   <= next_kind(kind);
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                state  <= ST_MACK;
                sda_oe <= 1'b0;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= sda_lvl;
            end else if (scl_fall) begin
              if (!mack && ptr_nx < LAST) begin
                ptr    <= ptr_nx;
                state  <= ST_TX;
                txsh   <= rdata;
                sda_oe <= ~rdata[7];
                bitcnt <= '0;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_seq_regfile.sv
module i2c_seq_regfile
  import i2c_seq_pkg::*;
#(
  parameter int         NREG       = 8,
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter logic [7:0] RESET_BYTE = 8'h3C,
  parameter int         SYNC_STG   = 2,
  localparam int        IW         = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  logic [1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst(rst), .line_i(raw[g]),
      .level_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  logic scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign start_evt = fall[1] & lvl[0];
  assign stop_evt  = rise[1] & lvl[0];

  logic          reg_we;
  logic [IW-1:0] widx, ridx;
  logic [7:0]    wdata, rdata;
  bus_st_e       bus_state;

  i2c_seq_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(lvl[1]),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_oe(sda_oe_o), .we(reg_we), .widx(widx), .wdata(wdata),
    .ridx(ridx), .rdata(rdata), .state_o(bus_state)
  );

  i2c_reg_bank #(.NREG(NREG), .RESET_BYTE(RESET_BYTE)) u_bank (
    .clk(clk), .rst(rst), .we(reg_we), .widx(widx), .wdata(wdata),
    .ridx(ridx), .rdata(rdata), .regs_o(regs_o)
  );
endmodule

// File: rtl/i2c_seq_regfile_chk.sv
module i2c_seq_regfile_chk
  import i2c_seq_pkg::*;
#(
  parameter int         NREG       = 8,
  parameter logic [7:0] RESET_BYTE = 8'h3C
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe_o,
  input logic [NREG*8-1:0] regs_o,
  input bus_st_e           state,
  input logic              scl_fall,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              reg_we
);
  // R1
  reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs_o == {NREG{RESET_BYTE}} && !sda_oe_o));

  // R3
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe_o);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe_o);

  // R9
  drive_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_evt || stop_evt));

  // R5
  reg_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs_o) |-> $past(reg_we));
endmodule

bind i2c_seq_regfile i2c_seq_regfile_chk #(.NREG(NREG), .RESET_BYTE(RESET_BYTE)) u_chk (
  .clk(clk), .rst(rst), .sda_oe_o(sda_oe_o), .regs_o(regs_o),
  .state(bus_state), .scl_fall(scl_fall), .start_evt(start_evt),
  .stop_evt(stop_evt), .reg_we(reg_we)
);

// File: tb/i2c_seq_regfile_test.sv
`timescale 1ns/1ps
module i2c_seq_regfile_test;
  localparam int NREG = 8;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  bus_sda = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_seq_regfile uut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int n_chk = 0, n_fail = 0;
  bit idle = 1'b0, done = 1'b0;
  logic [7:0] model [NREG];

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[8*i +: 8] = model[i];
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R5 reference comparison on every clock while the bus is quiet
  always @(negedge clk) begin
    if (idle && !rst) chk(regs === model_flat(), "R5 model compare", regs, model_flat());
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_b(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    ack = (bus_sda == 1'b0);
    wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_b(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1'b1; wq(Q); b[i] = bus_sda; wq(Q); m_scl = 1'b0;
    end
    wq(Q); m_sda = give_ack ? 1'b0 : 1'b1;
    wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q); m_sda = 1'b1;
  endtask

  task automatic settle();
    wq(8); idle = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // write: address, command, count, then data list; checks all acknowledges
  task automatic write_seq(input logic [7:0] cmd, input logic [7:0] data [$], input string tag);
    bit a;
    idle = 1'b0;
    start_c();
    send_b(8'hD2, a); chk(a, {"R2 write address ack ", tag}, a, 1);
    send_b(cmd, a);   chk(a, {"R4 command ack ", tag}, a, 1);
    send_b(8'h05, a); chk(a, {"R4 count ack ", tag}, a, 1);
    foreach (data[i]) begin
      send_b(data[i], a);
      if (i < NREG) begin
        chk(a, {"R5 data ack ", tag}, a, 1);
        model[i] = data[i];
      end else begin
        chk(!a, {"R8 data past end nack ", tag}, a, 0);
      end
    end
    stop_c();
    settle();
  endtask

  task automatic read_seq(input int n, input string tag);
    bit a;
    logic [7:0] b;
    idle = 1'b0;
    start_c();
    send_b(8'hD3, a); chk(a, {"R2 read address ack ", tag}, a, 1);
    for (int i = 0; i < n; i++) begin
      recv_b(i != n - 1, b);
      if (i < NREG) chk(b == model[i], {"R6 read data ", tag}, b, model[i]);
      else          chk(b == 8'hFF, {"R8 read past end ", tag}, b, 8'hFF);
    end
    stop_c();
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    logic [7:0] d [$];
    for (int i = 0; i < NREG; i++) model[i] = 8'h3C;
    wq(6); rst = 1'b0; wq(2);
    // R1 reset state
    chk(regs == {NREG{8'h3C}}, "R1 reset registers", regs, {NREG{8'h3C}});
    chk(sda_oe == 1'b0, "R1 reset drive", sda_oe, 0);
    settle();

    d = '{8'h11, 8'h22, 8'h33};
    write_seq(8'h00, d, "short");
    chk(regs[24 +: 8] == 8'h3C, "R5 untouched reg3", regs[24 +: 8], 8'h3C);

    d = '{8'hAA};
    write_seq(8'h7E, d, "nonzero cmd");
    chk(regs[15:0] == 16'h22AA, "R4 cmd not stored, R5 reg1 kept", regs[15:0], 16'h22AA);

    read_seq(4, "four");

    // R3 foreign address: nothing acknowledged, nothing stored
    idle = 1'b0;
    start_c();
    send_b(8'hA4, a); chk(!a, "R3 foreign address nack", a, 0);
    send_b(8'h00, a); chk(!a, "R3 ignored cmd", a, 0);
    send_b(8'h01, a); chk(!a, "R3 ignored count", a, 0);
    send_b(8'h99, a); chk(!a, "R3 ignored data", a, 0);
    stop_c();
    settle();
    chk(regs[7:0] == 8'hAA, "R3 reg0 unchanged", regs[7:0], 8'hAA);

    // R7 nack ends read: next byte clocked reads as released line
    idle = 1'b0;
    start_c();
    send_b(8'hD3, a); chk(a, "R2 read address ack", a, 1);
    recv_b(1'b0, b);  chk(b == 8'hAA, "R6 reg0 first", b, 8'hAA);
    recv_b(1'b0, b);  chk(b == 8'hFF, "R7 after nack line released", b, 8'hFF);
    chk(sda_oe == 1'b0, "R7 drive off after nack", sda_oe, 0);
    stop_c();
    chk(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);
    settle();

    // R8 full write plus one extra byte; then read past the end
    d = '{8'h01, 8'h12, 8'h23, 8'h34, 8'h45, 8'h56, 8'h67, 8'h78, 8'h89};
    write_seq(8'h00, d, "full");
    read_seq(NREG + 1, "full");

    // R9 repeated start inside a write restarts at the address byte
    idle = 1'b0;
    start_c();
    send_b(8'hD2, a); send_b(8'h00, a);
    start_c();
    send_b(8'hD2, a); chk(a, "R9 address after restart", a, 1);
    send_b(8'h00, a); send_b(8'h02, a);
    send_b(8'h55, a); chk(a, "R9 data ack after restart", a, 1);
    model[0] = 8'h55;
    // R9 repeated start turns it into a read from register 0
    start_c();
    send_b(8'hD3, a); chk(a, "R9 read address after restart", a, 1);
    recv_b(1'b1, b);  chk(b == 8'h55, "R9 reg0 after restart", b, 8'h55);
    recv_b(1'b0, b);  chk(b == 8'h12, "R9 reg1 kept", b, 8'h12);
    stop_c();
    settle();
    chk(regs[15:0] == 16'h1255, "R9 registers after restart", regs[15:0], 16'h1255);

    done = 1'b1;
    finish_run();
  end
endmodule